// File: doc/BRIEF.md
# Buffered Serial Peripheral Master with Loopback

This block drives a serial peripheral bus as a master. A 16-bit write port queues words into a four-entry transmit queue. A shift engine takes each word and sends its top 1 to 16 bits, most significant bit first, on a data output. It also produces a serial clock and an active-low device select. The clock polarity, the clock phase, the character length and a bit-rate divisor are all configuration inputs. The serial clock runs at the core clock divided by (divisor + 1).

Every character that is shifted out is also shifted in, so each one lands in a four-entry receive queue, right-justified. In loopback (three-wire) mode the receive shifter samples the block's own data output, and the separate input pin is ignored. In that mode the master reads back what it sent, and software can count received words to tell when a burst has finished. The data output enable tells the pad ring when the shared line is driven.

A hold input keeps the shift engine idle while the configuration is being changed. Words already queued stay in the queue and are sent after release. Queued words go out back to back with the select held low, and the select rises as soon as the last queued character ends.

Top module: `spi_fifo_master`

## Requirements
- R1: After rst_n, ste_n is 1, sclk equals cpol, mosi_oe is 0, tx_level and rx_count are 0, and tx_ovf and rx_ovf are 0.
- R2: A char_len value of N sends N+1 bits per character. These are bits 15 down to 15-N of the queued word, most significant first.
- R3: One bit lasts T = D+1 core clock cycles, where D is baud_div. A baud_div of 0 behaves as 1. Successive bits follow each other at exactly T cycles, including across character boundaries inside a burst.
- R4: The idle sclk level equals cpol. Data changes at the start of each bit, and the sampling edge comes floor(T/2) cycles later. With cpha 0, sclk leaves the idle level at the start of the bit, and the sampling edge is the return to idle. With cpha 1, data is presented half a bit before the first edge, and the sampling edge is the departure from idle.
- R5: ste_n falls when the first queued word is taken. It stays low while the transmit queue keeps supplying words, with no gap between characters, and it rises right after the last character.
- R6: With three_wire set, the received bits are the transmitted bits. With three_wire clear, they are the values on miso at the sampling edges.
- R7: Each finished character raises rx_count by one, T - floor(T/2) cycles after its last sampling edge. Its bits are right-justified in the received word, and all upper bits are zero.
- R8: rd_data shows the oldest received word, and a cycle with rd_en pops it. An rd_en with an empty receive queue changes nothing.
- R9: The transmit queue holds 4 words. A write to a full queue is dropped, and it sets tx_ovf, which stays set until rst_n.
- R10: A character that finishes while the receive queue holds 4 words, with no pop in that cycle, is dropped and sets rx_ovf. rx_ovf_clr clears the flag. If a pop falls in the same cycle, the character is stored.
- R11: While hold_rst is 1, nothing is shifted and ste_n stays 1. Queued words are kept and sent after release.
- R12: mosi_oe is 1 exactly while ste_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_rst | input | 1 | Holds shift engine idle |
| cpol | input | 1 | Idle level of sclk |
| cpha | input | 1 | Clock phase select |
| char_len | input | 4 | Bits per character minus one |
| baud_div | input | 8 | Bit-rate divisor |
| three_wire | input | 1 | Receive from own data output |
| wr_en | input | 1 | Push wr_data into transmit queue |
| wr_data | input | 16 | Left-justified transmit word |
| tx_level | output | 3 | Words in transmit queue |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rd_en | input | 1 | Pop receive queue |
| rd_data | output | 16 | Oldest received word, right-justified |
| rx_count | output | 3 | Words in receive queue |
| rx_ovf | output | 1 | Receive overflow flag |
| rx_ovf_clr | input | 1 | Clears rx_ovf |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Drive enable for the data line |
| miso | input | 1 | Serial data in |
| ste_n | output | 1 | Active-low device select |

## Verification
The collision of interest is a completed character entering a full receive queue in the same cycle that the reader pops it. To provoke it, the bench fills the receive queue with four words and sends one more 8-bit character with a divisor of 3. It waits for the eighth sampling edge and raises rd_en for exactly the single cycle R7 predicts for the push. The collision is judged correct if rx_overflow stays clear, the count stays at four, and the queue then yields the three surviving words followed by the new one. A following character with no pop must instead set the flag and leave the contents unchanged.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_SHIFT = 1'b1
   } shift_state_e;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 4,
   parameter int AW    = $clog2(DEPTH),
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic [CW-1:0]    count,
   output logic             accept
);
   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("spi_word_fifo: DEPTH must be a power of two and at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    rd_ptr, wr_ptr;
   logic             do_pop;

   assign do_pop = pop && (count != '0);
   assign accept = push && ((count != CW'(DEPTH)) || do_pop);
   assign head   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (accept) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (accept) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop) rd_ptr <= rd_ptr + 1'b1;
         if (accept && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !accept) count <= count - 1'b1;
      end
   end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
   import spi_fifo_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int DIV_W  = 8,
   parameter int LEN_W  = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              cpol,
   input  logic              cpha,
   input  logic [LEN_W-1:0]  char_len,
   input  logic [DIV_W-1:0]  baud_div,
   input  logic              three_wire,
   input  logic              miso,
   input  logic              tx_valid,
   input  logic [WORD_W-1:0] tx_word,
   output logic              tx_pop,
   output logic              rx_push,
   output logic [WORD_W-1:0] rx_word,
   output logic              sclk,
   output logic              mosi,
   output logic              mosi_oe,
   output logic              ste_n
);
   generate
      if (WORD_W < 2 || (1 << LEN_W) != WORD_W) begin : g_bad_word
         $error("spi_shift_engine: WORD_W must be a power of two");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("spi_shift_engine: DIV_W must be at least 1");
      end
   endgenerate

   localparam logic [WORD_W-1:0] ALL_ONES = '1;

   shift_state_e      state;
   logic [DIV_W-1:0]  cnt;
   logic [LEN_W-1:0]  bit_idx;
   logic [WORD_W-1:0] shreg, rxsh, rx_next;
   logic [DIV_W-1:0]  eff_div;
   logic [DIV_W:0]    half;
   logic              active, at_mid, at_end, last_bit, rx_in;

   assign eff_div  = (baud_div == '0) ? DIV_W'(1) : baud_div;
   assign half     = ({1'b0, eff_div} + 1'b1) >> 1;
   assign active   = (state == ST_SHIFT);
   assign at_mid   = active && ({1'b0, cnt} == half);
   assign at_end   = active && (cnt == eff_div);
   assign last_bit = (bit_idx == char_len);

   assign mosi    = active & shreg[WORD_W-1];
   assign mosi_oe = active;
   assign ste_n   = ~active;
   assign sclk    = cpol ^ (active & (cpha ? ({1'b0, cnt} >= half)
                                           : ({1'b0, cnt} <  half)));
   assign rx_in   = three_wire ? mosi : miso;

   always_comb begin
      rx_next = rxsh;
      if (at_mid) rx_next = {rxsh[WORD_W-2:0], rx_in};
      rx_word = rx_next & (ALL_ONES >> (WORD_W - 1 - int'(char_len)));
   end

   assign rx_push = !hold && at_end && last_bit;
   assign tx_pop  = !hold && tx_valid && (!active || rx_push);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         bit_idx <= '0;
         shreg   <= '0;
         rxsh    <= '0;
      end else if (hold) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         bit_idx <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (tx_valid) begin
                  state   <= ST_SHIFT;
                  shreg   <= tx_word;
                  cnt     <= '0;
                  bit_idx <= '0;
               end
            end
            default: begin
               rxsh <= rx_next;
               if (at_end) begin
                  cnt <= '0;
                  if (last_bit) begin
                     bit_idx <= '0;
                     if (tx_valid) shreg <= tx_word;
                     else          state <= ST_IDLE;
                  end else begin
                     shreg   <= shreg << 1;
                     bit_idx <= bit_idx + 1'b1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
   parameter int WORD_W     = 16,
   parameter int FIFO_DEPTH = 4,
   parameter int DIV_W      = 8,
   parameter int LEN_W      = $clog2(WORD_W),
   parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_rst,
   input  logic              cpol,
   input  logic              cpha,
   input  logic [LEN_W-1:0]  char_len,
   input  logic [DIV_W-1:0]  baud_div,
   input  logic              three_wire,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic [CNT_W-1:0]  tx_level,
   output logic              tx_ovf,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data,
   output logic [CNT_W-1:0]  rx_count,
   output logic              rx_ovf,
   input  logic              rx_ovf_clr,
   output logic              sclk,
   output logic              mosi,
   output logic              mosi_oe,
   input  logic              miso,
   output logic              ste_n
);
   logic [WORD_W-1:0] tx_head, rx_word;
   logic              tx_pop, tx_accept, rx_push, rx_accept;

   spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(wr_en), .push_data(wr_data),
      .pop(tx_pop), .head(tx_head),
      .count(tx_level), .accept(tx_accept)
   );

   spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push), .push_data(rx_word),
      .pop(rd_en), .head(rd_data),
      .count(rx_count), .accept(rx_accept)
   );

   spi_shift_engine #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .hold(hold_rst),
      .cpol(cpol), .cpha(cpha), .char_len(char_len),
      .baud_div(baud_div), .three_wire(three_wire), .miso(miso),
      .tx_valid(tx_level != '0), .tx_word(tx_head), .tx_pop(tx_pop),
      .rx_push(rx_push), .rx_word(rx_word),
      .sclk(sclk), .mosi(mosi), .mosi_oe(mosi_oe), .ste_n(ste_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_ovf <= 1'b0;
         rx_ovf <= 1'b0;
      end else begin
         tx_ovf <= tx_ovf | (wr_en & ~tx_accept);
         rx_ovf <= (rx_ovf & ~rx_ovf_clr) | (rx_push & ~rx_accept);
      end
   end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
   parameter int FIFO_DEPTH = 4,
   parameter int CNT_W      = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hold_rst,
   input logic             cpol,
   input logic             wr_en,
   input logic [CNT_W-1:0] tx_level,
   input logic             tx_ovf,
   input logic [CNT_W-1:0] rx_count,
   input logic             rx_ovf,
   input logic             rx_ovf_clr,
   input logic             sclk,
   input logic             ste_n
);
   p_idle_sclk_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ste_n |-> (sclk == cpol));

   p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      hold_rst |=> ste_n);

   p_rx_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count <= CNT_W'(FIFO_DEPTH));

   p_rx_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_count) |-> ((rx_count == $past(rx_count) + 1'b1) ||
                              (rx_count == $past(rx_count) - 1'b1)));

   p_full_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_rst && wr_en && tx_level == CNT_W'(FIFO_DEPTH))
         |=> (tx_ovf && tx_level == CNT_W'(FIFO_DEPTH)));

   p_tx_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ovf |=> tx_ovf);

   p_rx_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ovf_clr && rx_count < CNT_W'(FIFO_DEPTH)) |=> !rx_ovf);
endmodule

bind spi_fifo_master spi_fifo_master_chk #(
   .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .hold_rst(hold_rst), .cpol(cpol),
   .wr_en(wr_en), .tx_level(tx_level), .tx_ovf(tx_ovf),
   .rx_count(rx_count), .rx_ovf(rx_ovf), .rx_ovf_clr(rx_ovf_clr),
   .sclk(sclk), .ste_n(ste_n)
);

// File: tb/tb_spi_fifo_master.sv
module tb_spi_fifo_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hold_rst = 1'b0, cpol = 1'b0, cpha = 1'b0, three_wire = 1'b1;
   logic [3:0]  char_len = 4'd7;
   logic [7:0]  baud_div = 8'd1;
   logic        wr_en = 1'b0, rd_en = 1'b0, rx_ovf_clr = 1'b0;
   logic [15:0] wr_data = '0;
   logic [2:0]  tx_level, rx_count;
   logic        tx_ovf, rx_ovf, sclk, mosi, mosi_oe, ste_n;
   logic [15:0] rd_data;
   logic        miso;

   assign miso = ~mosi;

   spi_fifo_master dut (
      .clk(clk), .rst_n(rst_n), .hold_rst(hold_rst), .cpol(cpol), .cpha(cpha),
      .char_len(char_len), .baud_div(baud_div), .three_wire(three_wire),
      .wr_en(wr_en), .wr_data(wr_data), .tx_level(tx_level), .tx_ovf(tx_ovf),
      .rd_en(rd_en), .rd_data(rd_data), .rx_count(rx_count), .rx_ovf(rx_ovf),
      .rx_ovf_clr(rx_ovf_clr), .sclk(sclk), .mosi(mosi), .mosi_oe(mosi_oe),
      .miso(miso), .ste_n(ste_n)
   );

   always #2 clk = ~clk;

   int checks = 0, errors = 0;
   bit done = 0;

   // serial monitor state
   logic        cap_bits [512];
   int          cap_n = 0, ste_falls = 0, idle_bad = 0, oe_bad = 0;
   int          per_min = 0, per_max = 0, last_edge = -1, cyc = 0;
   logic        sclk_prev = 1'b0, ste_prev = 1'b1;
   logic [15:0] txw [8];

   always @(negedge clk) begin
      cyc++;
      if (ste_prev && !ste_n) ste_falls++;
      if (ste_n && sclk !== cpol) idle_bad++;
      if (mosi_oe !== !ste_n) oe_bad++;
      if (ste_n) last_edge = -1;
      else if (sclk !== sclk_prev && sclk === (cpol ^ cpha)) begin
         if (cap_n < 512) cap_bits[cap_n] = mosi;
         cap_n++;
         if (last_edge >= 0) begin
            if (per_min == 0 || cyc - last_edge < per_min) per_min = cyc - last_edge;
            if (cyc - last_edge > per_max) per_max = cyc - last_edge;
         end
         last_edge = cyc;
      end
      sclk_prev = sclk;
      ste_prev  = ste_n;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clear_mon();
      cap_n = 0; ste_falls = 0; idle_bad = 0; oe_bad = 0;
      per_min = 0; per_max = 0;
   endtask

   task automatic push_word(input logic [15:0] w);
      wr_data = w; wr_en = 1'b1;
      @(negedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic wait_burst();
      bit started = 0;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk); #1;
         if (!ste_n) started = 1;
         if (started && ste_n) break;
      end
      repeat (2) @(negedge clk);
      #1;
   endtask

   task automatic pop_check(input logic [15:0] exp, input string req);
      chk(rd_data === exp, req, "received word", int'(rd_data), int'(exp));
      rd_en = 1'b1;
      @(negedge clk); #1;
      rd_en = 1'b0;
   endtask

   function automatic logic [15:0] rj(input logic [15:0] w, input int len);
      return w >> (15 - len);
   endfunction

   // one burst of n words under a configuration, fully checked
   task automatic burst(input logic pol, input logic pha, input int len,
                        input int div, input logic tw, input int n, input int seed);
      int  t, bad;
      @(negedge clk); #1;
      hold_rst = 1'b1; cpol = pol; cpha = pha; char_len = 4'(len);
      baud_div = 8'(div); three_wire = tw;
      for (int k = 0; k < n; k++) begin
         txw[k] = 16'hA5C3 ^ 16'(seed * 16'h1357) ^ 16'(k * 16'h2F1B);
         push_word(txw[k]);
      end
      clear_mon();
      hold_rst = 1'b0;
      wait_burst();
      t = ((div == 0) ? 1 : div) + 1;
      bad = 0;
      for (int k = 0; k < n; k++)
         for (int i = 0; i <= len; i++)
            if (cap_bits[k*(len+1)+i] !== txw[k][15-i]) bad++;
      chk(cap_n == n*(len+1), "R2", "bit count", cap_n, n*(len+1));
      chk(bad == 0, "R2", "bit values MSB first", bad, 0);
      if (n*(len+1) > 1)
         chk(per_min == t && per_max == t, "R3", "bit period", per_max, t);
      chk(ste_falls == 1, "R5", "select stays low across words", ste_falls, 1);
      chk(idle_bad == 0, "R4", "idle sclk level", idle_bad, 0);
      chk(oe_bad == 0, "R12", "output enable tracks select", oe_bad, 0);
      chk(rx_count == 3'(n), "R7", "rx count", int'(rx_count), n);
      for (int k = 0; k < n; k++)
         pop_check(tw ? rj(txw[k], len) : rj(~txw[k], len), tw ? "R6" : "R6_miso");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk(ste_n === 1'b1, "R1", "ste_n", int'(ste_n), 1);
      chk(sclk === cpol && mosi_oe === 1'b0, "R1", "sclk/oe", int'(sclk), 0);
      chk(tx_level == 0 && rx_count == 0, "R1", "levels", int'(rx_count), 0);
      chk(!tx_ovf && !rx_ovf, "R1", "flags", int'(tx_ovf), 0);
      rst_n = 1'b1;
      @(negedge clk); #1;

      // R8 read while empty is ignored
      rd_en = 1'b1; @(negedge clk); #1; rd_en = 1'b0;
      chk(rx_count == 0, "R8", "pop on empty", int'(rx_count), 0);

      // R2 R3 R4 R5 R6 R7: sweep modes, lengths and divisors with loopback
      begin
         int seed = 0;
         int lens [4] = '{0, 3, 7, 15};
         int divs [4] = '{0, 1, 2, 5};
         for (int m = 0; m < 4; m++)
            for (int li = 0; li < 4; li++)
               for (int di = 0; di < 4; di++) begin
                  burst(m[1], m[0], lens[li], divs[di], 1'b1, 3, seed);
                  seed++;
               end
         // R6 pin receive path
         for (int m = 0; m < 4; m++) burst(m[1], m[0], 7, 2, 1'b0, 2, 100 + m);
      end

      // R11 hold keeps queued words and shifts nothing
      @(negedge clk); #1;
      hold_rst = 1'b1; cpol = 0; cpha = 0; char_len = 4'd7; baud_div = 8'd3;
      three_wire = 1'b1;
      push_word(16'h5A00); push_word(16'hC300);
      clear_mon();
      repeat (40) @(negedge clk);
      #1;
      chk(ste_falls == 0 && cap_n == 0, "R11", "no activity under hold", cap_n, 0);
      chk(tx_level == 2 && rx_count == 0, "R11", "queue kept", int'(tx_level), 2);
      hold_rst = 1'b0;
      wait_burst();
      pop_check(16'h005A, "R11");
      pop_check(16'h00C3, "R11");

      // R10 push and pop collide on a full receive queue
      @(negedge clk); #1;
      hold_rst = 1'b1;
      for (int k = 0; k < 4; k++) begin
         txw[k] = 16'(16'h1100 * (k + 1));
         push_word(txw[k]);
      end
      hold_rst = 1'b0;
      wait_burst();
      chk(rx_count == 4, "R10", "queue filled", int'(rx_count), 4);
      hold_rst = 1'b1;
      txw[4] = 16'h9E00;
      push_word(txw[4]);
      clear_mon();
      hold_rst = 1'b0;
      while (cap_n < 8) begin @(negedge clk); #1; end
      @(negedge clk); #1;
      rd_en = 1'b1;          // high only across the push edge (T=4, floor(T/2)=2)
      @(negedge clk); #1;
      rd_en = 1'b0;
      wait_burst();
      chk(!rx_ovf, "R10", "no overflow on push with pop", int'(rx_ovf), 0);
      chk(rx_count == 4, "R10", "count after collide", int'(rx_count), 4);
      // R10 overflow when full without pop
      hold_rst = 1'b1;
      push_word(16'h7700);
      hold_rst = 1'b0;
      wait_burst();
      chk(rx_ovf, "R10", "overflow set", int'(rx_ovf), 1);
      chk(rx_count == 4, "R10", "count after drop", int'(rx_count), 4);
      rx_ovf_clr = 1'b1; @(negedge clk); #1; rx_ovf_clr = 1'b0;
      chk(!rx_ovf, "R10", "overflow cleared", int'(rx_ovf), 0);
      for (int k = 1; k < 5; k++) pop_check(rj(txw[k], 7), "R10");

      // R9 transmit queue overflow
      @(negedge clk); #1;
      hold_rst = 1'b1;
      for (int k = 0; k < 5; k++) begin
         txw[k] = 16'(16'h2300 + k * 16'h1400);
         push_word(txw[k]);
      end
      chk(tx_level == 4, "R9", "tx level capped", int'(tx_level), 4);
      chk(tx_ovf, "R9", "tx overflow set", int'(tx_ovf), 1);
      hold_rst = 1'b0;
      wait_burst();
      chk(rx_count == 4, "R9", "four words sent", int'(rx_count), 4);
      for (int k = 0; k < 4; k++) pop_check(rj(txw[k], 7), "R9");
      chk(tx_ovf, "R9", "tx overflow sticky", int'(tx_ovf), 1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule